// File: doc/BRIEF.md
# Permission-Tracked Set-Associative Tag Store

This block is a tag directory for a set-associative cache. Every way of every set holds a stored line address, a two-bit access permission and a small line of byte data. The set is chosen by the low bits of the line address. The permission separates an empty way from a way that has been reserved but has no usable data yet, and from read-only and read-write lines. A controller drives one command per cycle on a valid/opcode interface. The block answers one cycle later with a hit flag, the way that was selected, the permission of the line, a victim line address, a data byte and an error flag.

Each set keeps a true least-recently-used order in per-way age counters. Lookups that match a line refresh that line's age, and so do explicit refresh commands and allocations. The victim probe names the oldest way. Coherence actions, miss handling and the next level of memory stay with the controller.

Top module: `perm_tag_store`

## Requirements
- R1: After reset every way holds address 0 with permission code 0 (empty, NotPresent). A presence test of line 0 then misses, and an availability test of line 0 succeeds.
- R2: A way matches only when its stored address equals the request line address and its permission is not 0. When several ways match, the lowest-numbered one is reported on rsp_way. The presence test (op 1) reports the match, with rsp_perm giving the matched permission.
- R3: The access check (op 0) hits on a permission 3 (read-write) line for every request type. On a permission 2 (read-only) line it hits only for request 0 (load) or 1 (fetch), and misses for 2 (store). A line with permission 1 (reserved) never hits. rsp_perm reports the matched line's permission.
- R4: An access check that matches a line makes that way most recently used, even when the permission check fails.
- R5: The availability test (op 2) returns true when any way of the set has an equal stored address, whatever its permission, or when any way of the set is empty.
- R6: Allocate (op 3) takes the lowest-numbered empty way. It writes the line address, sets the permission to 1, clears the line's data bytes and makes the way most recently used. rsp_way returns the way it took.
- R7: Deallocate (op 4) sets the matched line's permission to 0 and keeps its stored address. Permission read (op 5) reports the permission. Permission change (op 6) writes cmd_perm.
- R8: The victim probe (op 7) returns the stored address and the index of the least recently used way of the set. It does not change the recency order.
- R9: Recency is true LRU. After reset the ways are ordered by index, with the highest index oldest. A touched way becomes youngest, and only the ways that were younger than it age by one. The refresh command (op 8) touches the matched line.
- R10: Byte read (op 9) and byte write (op 10) locate the line by the line address cmd_addr[ADDR_W-1:OFF_BITS]. The byte within the line is the request address minus the line-aligned address, which is cmd_addr[OFF_BITS-1:0].
- R11: Some commands raise rsp_err for one response and change no tag, permission, recency or data state. These are an allocation into a set with no empty way, and ops 4, 5, 6, 8, 9 or 10 on a line that does not match. rsp_hit is 0 whenever rsp_err is 1.
- R12: rsp_valid is 1 exactly in the cycle after a cycle with cmd_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode 0..10 as in the requirements |
| cmd_addr | input | ADDR_W | Byte address; the upper LINE_W bits are the line address |
| cmd_req | input | 2 | Request type: 0 load, 1 fetch, 2 store |
| cmd_perm | input | 2 | New permission for op 6 |
| cmd_wdata | input | 8 | Byte written by op 10 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit or success of the command |
| rsp_err | output | 1 | Command refused; state unchanged |
| rsp_way | output | WAY_W | Matched, allocated or victim way |
| rsp_perm | output | 2 | Permission of the matched line before the command |
| rsp_victim | output | LINE_W | Stored address of the set's LRU way |
| rsp_rdata | output | 8 | Byte read by op 9 |

## Verification
The bench fills a set and checks that allocation lands in ascending ways. A full-set allocation is refused, and a later probe shows the order was not disturbed. A design that skipped the empty-way check would overwrite a live line. Permission-denied accesses are checked to move their way out of the victim slot. A design that touched only on a hit would still name the old way. A deallocated line is made the oldest way so that the probe exposes its kept address. A duplicate address in two ways checks that the lowest way matches, and that it is the one a deallocate removes. Byte offsets and the clearing of data on reallocation are checked through byte reads.

// File: rtl/ts_pkg.sv
package ts_pkg;

   typedef enum logic [3:0] {
      OP_ACCESS  = 4'd0,
      OP_PRESENT = 4'd1,
      OP_AVAIL   = 4'd2,
      OP_ALLOC   = 4'd3,
      OP_DEALLOC = 4'd4,
      OP_GETPERM = 4'd5,
      OP_SETPERM = 4'd6,
      OP_PROBE   = 4'd7,
      OP_TOUCH   = 4'd8,
      OP_RDBYTE  = 4'd9,
      OP_WRBYTE  = 4'd10
   } ts_op_e;

   typedef enum logic [1:0] {
      PERM_NONE = 2'd0,
      PERM_RSVD = 2'd1,
      PERM_RO   = 2'd2,
      PERM_RW   = 2'd3
   } ts_perm_e;

   typedef enum logic [1:0] {
      REQ_LOAD  = 2'd0,
      REQ_FETCH = 2'd1,
      REQ_STORE = 2'd2
   } ts_req_e;

endpackage

// File: rtl/ts_lookup.sv
module ts_lookup #(
   parameter int WAYS   = 4,
   parameter int LINE_W = 12,
   parameter int WAY_W  = 2
) (
   input  logic [WAYS-1:0][LINE_W-1:0] tags,
   input  logic [WAYS-1:0][1:0]        perms,
   input  logic [LINE_W-1:0]           line,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic                        addr_any,
   output logic                        free_any,
   output logic [WAY_W-1:0]            free_way
);
   import ts_pkg::*;

   logic [WAYS-1:0] addr_eq;
   logic [WAYS-1:0] live_eq;
   logic [WAYS-1:0] empty;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign addr_eq[w] = (tags[w] == line);
      assign empty[w]   = (perms[w] == PERM_NONE);
      assign live_eq[w] = addr_eq[w] && !empty[w];
   end

   assign hit      = |live_eq;
   assign addr_any = |addr_eq;
   assign free_any = |empty;

   // scan downward so the lowest index wins
   always_comb begin
      hit_way  = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (live_eq[w]) hit_way  = WAY_W'(w);
         if (empty[w])   free_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/ts_lru.sv
module ts_lru #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int SET_W = 2,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [SET_W-1:0] q_set,
   output logic [WAY_W-1:0] victim_way
);

   logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
   logic [WAY_W-1:0]                     ref_age;

   assign ref_age = age_q[touch_set][touch_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] < ref_age)
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   // ages form a permutation, so the maximum is unique
   always_comb begin
      victim_way = '0;
      for (int w = 1; w < WAYS; w++)
         if (age_q[q_set][w] > age_q[q_set][victim_way])
            victim_way = WAY_W'(w);
   end

endmodule

// File: rtl/ts_data.sv
module ts_data #(
   parameter int BYTES_TOTAL = 64,
   parameter int BYTES_LINE  = 4,
   parameter int IDX_W       = 6
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_byte,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_base,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_byte
);

   logic [7:0] mem_q [BYTES_TOTAL];

   always_ff @(posedge clk) begin
      if (clr_en) begin
         for (int b = 0; b < BYTES_LINE; b++)
            mem_q[clr_base + IDX_W'(b)] <= 8'h00;
      end else if (wr_en) begin
         mem_q[wr_idx] <= wr_byte;
      end
   end

   assign rd_byte = mem_q[rd_idx];

endmodule

// File: rtl/perm_tag_store.sv
module perm_tag_store #(
   parameter int SET_BITS = 2,
   parameter int WAYS     = 4,
   parameter int LINE_W   = 12,
   parameter int OFF_BITS = 2,
   localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int ADDR_W  = LINE_W + OFF_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [1:0]        cmd_req,
   input  logic [1:0]        cmd_perm,
   input  logic [7:0]        cmd_wdata,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_err,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [1:0]        rsp_perm,
   output logic [LINE_W-1:0] rsp_victim,
   output logic [7:0]        rsp_rdata
);
   import ts_pkg::*;

   localparam int SETS   = 1 << SET_BITS;
   localparam int BYTES  = 1 << OFF_BITS;
   localparam int TOTAL  = SETS * WAYS * BYTES;
   localparam int IDX_W  = SET_BITS + WAY_W + OFF_BITS;

   if (SET_BITS < 1 || SET_BITS >= LINE_W) begin : g_bad_sets
      $error("SET_BITS must lie in 1..LINE_W-1");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (OFF_BITS < 1) begin : g_bad_off
      $error("OFF_BITS must be at least 1");
   end

   // request decode
   ts_op_e              op;
   logic [LINE_W-1:0]   line;
   logic [SET_BITS-1:0] set_idx;
   logic [OFF_BITS-1:0] byte_off;

   assign op       = ts_op_e'(cmd_op);
   assign line     = cmd_addr[ADDR_W-1:OFF_BITS];
   assign set_idx  = line[SET_BITS-1:0];
   // address minus its line-aligned base is the low field
   assign byte_off = cmd_addr[OFF_BITS-1:0];

   // tag and permission state
   logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0][1:0]        perm_q;

   logic             lk_hit;
   logic [WAY_W-1:0] lk_way;
   logic             lk_addr_any;
   logic             lk_free_any;
   logic [WAY_W-1:0] lk_free_way;

   ts_lookup #(.WAYS(WAYS), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_lookup (
      .tags     (tag_q[set_idx]),
      .perms    (perm_q[set_idx]),
      .line     (line),
      .hit      (lk_hit),
      .hit_way  (lk_way),
      .addr_any (lk_addr_any),
      .free_any (lk_free_any),
      .free_way (lk_free_way)
   );

   // command qualification
   logic     needs_line;
   logic     err_c;
   logic     go;
   ts_perm_e hit_perm;
   logic     access_ok;

   always_comb begin
      needs_line = 1'b0;
      case (op)
         OP_DEALLOC, OP_GETPERM, OP_SETPERM,
         OP_TOUCH, OP_RDBYTE, OP_WRBYTE: needs_line = 1'b1;
         default:                        needs_line = 1'b0;
      endcase
   end

   assign err_c     = cmd_valid && ((needs_line && !lk_hit) ||
                                    (op == OP_ALLOC && !lk_free_any));
   assign go        = cmd_valid && !err_c;
   assign hit_perm  = lk_hit ? ts_perm_e'(perm_q[set_idx][lk_way]) : PERM_NONE;
   assign access_ok = (hit_perm == PERM_RW) ||
                      (hit_perm == PERM_RO && ts_req_e'(cmd_req) != REQ_STORE);

   // replacement state
   logic             touch_en;
   logic [WAY_W-1:0] touch_way;
   logic [WAY_W-1:0] victim_way;

   assign touch_en  = go && ((op == OP_ACCESS && lk_hit) ||
                             op == OP_TOUCH || op == OP_ALLOC);
   assign touch_way = (op == OP_ALLOC) ? lk_free_way : lk_way;

   ts_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_BITS), .WAY_W(WAY_W)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_set  (set_idx),
      .touch_way  (touch_way),
      .q_set      (set_idx),
      .victim_way (victim_way)
   );

   // line data
   logic [7:0]       rd_byte;
   logic [IDX_W-1:0] byte_idx;
   logic [IDX_W-1:0] clr_base;

   assign byte_idx = {set_idx, lk_way, byte_off};
   assign clr_base = {set_idx, lk_free_way, {OFF_BITS{1'b0}}};

   ts_data #(.BYTES_TOTAL(TOTAL), .BYTES_LINE(BYTES), .IDX_W(IDX_W)) u_data (
      .clk      (clk),
      .wr_en    (go && op == OP_WRBYTE),
      .wr_idx   (byte_idx),
      .wr_byte  (cmd_wdata),
      .clr_en   (go && op == OP_ALLOC),
      .clr_base (clr_base),
      .rd_idx   (byte_idx),
      .rd_byte  (rd_byte)
   );

   // tag and permission update
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q  <= '0;
         perm_q <= {SETS*WAYS{PERM_NONE}};
      end else if (go) begin
         case (op)
            OP_ALLOC: begin
               tag_q[set_idx][lk_free_way]  <= line;
               perm_q[set_idx][lk_free_way] <= PERM_RSVD;
            end
            OP_DEALLOC: perm_q[set_idx][lk_way] <= PERM_NONE;
            OP_SETPERM: perm_q[set_idx][lk_way] <= cmd_perm;
            default: ;
         endcase
      end
   end

   // response register
   logic             hit_c;
   logic [WAY_W-1:0] way_c;

   always_comb begin
      case (op)
         OP_ACCESS: hit_c = lk_hit && access_ok;
         OP_AVAIL:  hit_c = lk_addr_any || lk_free_any;
         OP_ALLOC:  hit_c = !err_c;
         OP_PROBE:  hit_c = 1'b1;
         default:   hit_c = lk_hit;
      endcase
      case (op)
         OP_ALLOC: way_c = lk_free_way;
         OP_PROBE: way_c = victim_way;
         default:  way_c = lk_way;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_err    <= 1'b0;
         rsp_way    <= '0;
         rsp_perm   <= PERM_NONE;
         rsp_victim <= '0;
         rsp_rdata  <= '0;
      end else begin
         rsp_valid  <= cmd_valid;
         rsp_hit    <= cmd_valid && !err_c && hit_c;
         rsp_err    <= err_c;
         rsp_way    <= way_c;
         rsp_perm   <= (op == OP_ALLOC) ? PERM_RSVD : hit_perm;
         rsp_victim <= tag_q[set_idx][victim_way];
         rsp_rdata  <= rd_byte;
      end
   end

endmodule

// File: rtl/ts_checker.sv
module ts_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [3:0] cmd_op,
   input logic [1:0] cmd_req,
   input logic       free_any,
   input logic       rsp_valid,
   input logic       rsp_hit,
   input logic       rsp_err,
   input logic [1:0] rsp_perm
);
   import ts_pkg::*;

   // R12: a response follows each command by one cycle
   p_rsp_follows_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);
   p_no_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);

   // R11: an error never reports success
   p_err_excludes_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && !rsp_hit));

   // R11: allocation fails exactly when the set had no empty way
   p_alloc_err_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ALLOC) |=> (rsp_err == !$past(free_any)));

   // R3: a store hit needs a read-write line
   p_store_needs_rw_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACCESS && cmd_req == REQ_STORE) |=>
         (!rsp_hit || rsp_perm == PERM_RW));

   // R3: any access hit needs a readable line
   p_access_hit_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACCESS) |=>
         (!rsp_hit || rsp_perm == PERM_RO || rsp_perm == PERM_RW));

   // R2: a presence hit never reports an empty way
   p_present_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_PRESENT) |=> (!rsp_hit || rsp_perm != PERM_NONE));

endmodule

bind perm_tag_store ts_checker u_ts_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_req   (cmd_req),
   .free_any  (lk_free_any),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_err   (rsp_err),
   .rsp_perm  (rsp_perm)
);

// File: tb/tb_perm_tag_store.sv
module tb_perm_tag_store;

   localparam int ADDR_W = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [3:0]        cmd_op = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [1:0]        cmd_req = '0;
   logic [1:0]        cmd_perm = '0;
   logic [7:0]        cmd_wdata = '0;
   logic              rsp_valid, rsp_hit, rsp_err;
   logic [1:0]        rsp_way, rsp_perm;
   logic [11:0]       rsp_victim;
   logic [7:0]        rsp_rdata;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   perm_tag_store dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
      .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_err(rsp_err), .rsp_way(rsp_way), .rsp_perm(rsp_perm),
      .rsp_victim(rsp_victim), .rsp_rdata(rsp_rdata)
   );

   // opcodes
   localparam logic [3:0] ACC = 0, PRS = 1, AVL = 2, ALC = 3, DEA = 4,
                          GTP = 5, STP = 6, PRB = 7, TCH = 8, RDB = 9, WRB = 10;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   // issue one command; outputs are sampled just after the response edge
   task automatic cmd(input logic [3:0] op, input logic [11:0] line,
                      input logic [1:0] off = 0, input logic [1:0] req = 0,
                      input logic [1:0] perm = 0, input logic [7:0] wd = 0);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = {line, off};
      cmd_req   = req;
      cmd_perm  = perm;
      cmd_wdata = wd;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      eq("R12 reset rsp_valid", rsp_valid, 0);
      cmd(PRS, 12'h000);
      eq("R1 line0 absent", rsp_hit, 0);
      eq("R12 rsp_valid after cmd", rsp_valid, 1);
      cmd(AVL, 12'h000);
      eq("R1 avail after reset", rsp_hit, 1);
      cmd(PRB, 12'h000);
      eq("R9 initial victim way", rsp_way, 3);
      eq("R1 cleared address", rsp_victim, 0);
      cmd(GTP, 12'h000);
      eq("R11 getperm absent err", rsp_err, 1);
      idle();
      eq("R12 idle no response", rsp_valid, 0);
   endtask

   task automatic t_fill();
      cmd(ALC, 12'h004); eq("R6 alloc way0", rsp_way, 0); eq("R6 alloc ok", rsp_hit, 1);
      cmd(GTP, 12'h004); eq("R6 reserved perm", rsp_perm, 1);
      cmd(ALC, 12'h008); eq("R6 alloc way1", rsp_way, 1);
      cmd(ALC, 12'h00C); eq("R6 alloc way2", rsp_way, 2);
      cmd(ALC, 12'h010); eq("R6 alloc way3", rsp_way, 3);
      cmd(AVL, 12'h014); eq("R5 full set unavailable", rsp_hit, 0);
      cmd(AVL, 12'h008); eq("R5 matching address available", rsp_hit, 1);
      cmd(ALC, 12'h014); eq("R11 alloc full err", rsp_err, 1); eq("R11 alloc full hit", rsp_hit, 0);
      cmd(PRB, 12'h014); eq("R9 victim way0", rsp_way, 0); eq("R8 victim addr", rsp_victim, 12'h004);
      cmd(PRS, 12'h014); eq("R11 failed alloc wrote nothing", rsp_hit, 0);
      cmd(PRS, 12'h004); eq("R2 presence way0", rsp_hit, 1);
   endtask

   task automatic t_access();
      cmd(STP, 12'h004, 0, 0, 2);
      cmd(ACC, 12'h004, 0, 0); eq("R3 RO load hit", rsp_hit, 1); eq("R3 perm RO", rsp_perm, 2);
      cmd(ACC, 12'h004, 0, 2); eq("R3 RO store miss", rsp_hit, 0);
      cmd(ACC, 12'h004, 0, 1); eq("R3 RO fetch hit", rsp_hit, 1);
      cmd(STP, 12'h008, 0, 0, 3);
      cmd(ACC, 12'h008, 0, 2); eq("R3 RW store hit", rsp_hit, 1);
      cmd(ACC, 12'h00C, 0, 0); eq("R3 reserved load miss", rsp_hit, 0);
      cmd(PRB, 12'h000); eq("R4 failed check touched way2", rsp_way, 3);
      cmd(ACC, 12'h010, 0, 2); eq("R3 reserved store miss", rsp_hit, 0);
      cmd(PRB, 12'h000); eq("R4 victim after denied access", rsp_way, 0);
      eq("R8 victim addr 004", rsp_victim, 12'h004);
      cmd(ACC, 12'h020, 0, 0); eq("R3 absent miss", rsp_hit, 0);
   endtask

   task automatic t_dealloc();
      cmd(DEA, 12'h004); eq("R7 dealloc ok", rsp_hit, 1);
      cmd(PRS, 12'h004); eq("R7 gone after dealloc", rsp_hit, 0);
      cmd(PRB, 12'h000); eq("R7 address kept", rsp_victim, 12'h004); eq("R8 probe way", rsp_way, 0);
      cmd(DEA, 12'h004); eq("R11 dealloc absent err", rsp_err, 1);
      cmd(AVL, 12'h014); eq("R5 freed way available", rsp_hit, 1);
      cmd(ALC, 12'h014); eq("R6 reuse lowest free", rsp_way, 0);
      cmd(PRB, 12'h000); eq("R9 LRU after realloc", rsp_way, 1); eq("R8 victim 008", rsp_victim, 12'h008);
   endtask

   task automatic t_lowest();
      cmd(DEA, 12'h00C);
      cmd(DEA, 12'h010);
      cmd(ALC, 12'h008); eq("R6 duplicate into way2", rsp_way, 2);
      cmd(PRS, 12'h008); eq("R2 lowest match way1", rsp_way, 1);
      cmd(DEA, 12'h008); eq("R2 dealloc lowest", rsp_way, 1);
      cmd(PRS, 12'h008); eq("R2 next match way2", rsp_way, 2); eq("R2 hit", rsp_hit, 1);
      cmd(STP, 12'h008, 0, 0, 3); eq("R7 setperm returns old", rsp_perm, 1);
      cmd(GTP, 12'h008); eq("R7 setperm applied", rsp_perm, 3);
   endtask

   task automatic t_bytes();
      cmd(ALC, 12'h005); eq("R6 set1 alloc way0", rsp_way, 0);
      cmd(WRB, 12'h005, 1, 0, 0, 8'hA5);
      cmd(WRB, 12'h005, 3, 0, 0, 8'h3C);
      cmd(RDB, 12'h005, 1); eq("R10 byte1", rsp_rdata, 8'hA5);
      cmd(RDB, 12'h005, 3); eq("R10 byte3", rsp_rdata, 8'h3C);
      cmd(RDB, 12'h005, 0); eq("R6 cleared byte0", rsp_rdata, 0);
      cmd(WRB, 12'h009, 1, 0, 0, 8'h77); eq("R11 write absent err", rsp_err, 1);
      cmd(RDB, 12'h009, 1); eq("R11 read absent err", rsp_err, 1);
      cmd(RDB, 12'h005, 1); eq("R11 absent write left data", rsp_rdata, 8'hA5);
      cmd(DEA, 12'h005);
      cmd(ALC, 12'h005);
      cmd(RDB, 12'h005, 1); eq("R6 realloc clears data", rsp_rdata, 0);
   endtask

   task automatic t_touch();
      cmd(ALC, 12'h002); cmd(ALC, 12'h006); cmd(ALC, 12'h00A); cmd(ALC, 12'h00E);
      cmd(PRB, 12'h002); eq("R9 fill victim way0", rsp_way, 0);
      cmd(TCH, 12'h002); eq("R9 touch ok", rsp_hit, 1);
      cmd(PRB, 12'h002); eq("R9 touch moves victim", rsp_way, 1); eq("R8 victim 006", rsp_victim, 12'h006);
      cmd(TCH, 12'h012); eq("R11 touch absent err", rsp_err, 1);
      cmd(PRB, 12'h002); eq("R11 touch absent no change", rsp_way, 1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_fill();
      t_access();
      t_dealloc();
      t_lowest();
      t_bytes();
      t_touch();
      idle();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule